// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block turns single-beat read and write requests from an internal request/acknowledge port into correctly sequenced strobes for an asynchronous static RAM. The memory has two chip selects, one active low and one active high. It also has two active-low byte-lane strobes, an active-low write enable, an active-low output enable and a width select. The controller drives the address and the outbound data. For each group of data pins it drives a separate enable, which the pad ring uses as the tri-state control. It captures inbound read data and returns it with the acknowledge.

Two data widths are supported on a per-request basis. In word mode the 16 data pins carry a full word, and the two request byte enables pick the lanes. In byte mode only pins 7:0 carry data. Pin 15 becomes an extra address input below the word address, and both lane strobes are held low. All memory timing is met by counting clock cycles. Every interval is given in nanoseconds as a parameter and rounded up to whole clock periods, with a minimum of one. A read is followed by a turnaround period, so the memory's output driver is off before the controller drives the bus again.

The request is held valid until a one-cycle acknowledge. The requester may present its next request in the cycle after the acknowledge.

Top module: `asram_ctrl`

## Requirements
- R1: The write enable is low only while chip select 1 is low, chip select 2 is high and at least one lane strobe is low. It falls at least one cycle after those selects assert, and the selects stay asserted for one cycle after it rises.
- R2: The output enable is low only while the write enable is high and the memory is selected. The value on `dq_in` in the last output-enable-low cycle is returned on `rsp_rdata` together with `req_ack`.
- R3: After reset, and whenever the memory is deselected (both lane strobes high, chip select 1 high or chip select 2 low), no data-pin drive enable is set. Reset leaves every strobe inactive and `mem_x16` high.
- R4: A byte-mode request (`req_byte_mode`=1) sets `mem_x16` low and holds both lane strobes low. It drives pin 15 with `req_addr[0]` and never drives pins 14:8. Writes place `req_wdata[7:0]` on pins 7:0. Reads return `{8'h00, dq_in[7:0]}`.
- R5: In word mode, `mem_lane_n[i]` is the inverse of `req_be[i]`. Lane 0 is pins 7:0 and lane 1 is pins 15:8. A write drives only the enabled lanes. The word address is `req_addr[ADDR_W:1]` in both modes.
- R6: A word-mode request with `req_be`=0 is acknowledged in the cycle after it is accepted, and no select or strobe asserts.
- R7: During a read the output enable stays low for exactly RD_CYC cycles. RD_CYC is the largest of the output-enable access time, the address access time less one cycle, and the read cycle time less one cycle, each in whole cycles.
- R8: During a write the write enable stays low for exactly WR_CYC cycles, with address and data stable throughout. WR_CYC is the largest of the write pulse width and, each less one cycle, the address-to-end time, the data setup time and the write cycle time.
- R9: After the output enable rises, no data pin is driven until at least TURN_CYC cycles have passed, where TURN_CYC is the output turn-off time in whole cycles.
- R10: `req_ack` is a one-cycle pulse. For a write it appears in the first cycle with the write enable high again. For a read it appears in the first cycle with the output enable high again. An accepted request takes 2+WR_CYC or 2+RD_CYC cycles to its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte_mode | input | 1 | 1 = 8-bit access, 0 = 16-bit access |
| req_addr | input | ADDR_W+1 | Byte address; bits ADDR_W:1 form the word address |
| req_be | input | 2 | Word-mode lane enables (bit 0 = pins 7:0) |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with req_ack |
| mem_addr | output | ADDR_W | Memory word address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_lane_n | output | 2 | Active-low lane strobes |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_x16 | output | 1 | Width select: 1 = word, 0 = byte |
| dq_out | output | 16 | Outbound data-pin values |
| dq_drv_lo | output | 1 | Drive enable for pins 7:0 |
| dq_drv_mid | output | 1 | Drive enable for pins 14:8 |
| dq_drv_top | output | 1 | Drive enable for pin 15 |
| dq_in | input | 16 | Inbound data-pin values |

## Verification
A wrong sequencer state shows up at the memory pins within one clock. It appears as a write or output enable asserted without a full select, as both enables low together, or as a drive enable set during a deselected or turnaround cycle. A miscounted interval appears when the strobe rises. The output-enable or write-enable low time then differs from RD_CYC or WR_CYC, and the acknowledge latency shifts by the same amount. A wrong lane or width decode stays hidden until a read returns data. The bench therefore reads every location back through a separate pin-level memory model and compares the result against its own shadow copy.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int unsigned DQ_W   = 16;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = DQ_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } ctl_state_e;

    // Memory control pins, all in their physical polarity.
    typedef struct packed {
        logic             cs1_n;
        logic             cs2;
        logic [LANES-1:0] lane_n;
        logic             we_n;
        logic             oe_n;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{cs1_n: 1'b1, cs2: 1'b0, lane_n: '1, we_n: 1'b1, oe_n: 1'b1};

    // Drive enables for the three data-pin groups.
    typedef struct packed {
        logic lo;
        logic mid;
        logic top;
    } drive_t;

    // Nanoseconds to whole clock periods, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/asram_lane_map.sv
module asram_lane_map
    import asram_pkg::*;
(
    input  logic             byte_mode,
    input  logic             is_write,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] lane_n,
    output logic             any_lane,
    output drive_t           drive
);
    always_comb begin
        if (byte_mode) begin
            lane_n   = '0;
            any_lane = 1'b1;
            drive.lo  = is_write;
            drive.mid = 1'b0;
            drive.top = 1'b1;           // pin 15 carries the low address bit
        end else begin
            lane_n   = ~be;
            any_lane = |be;
            drive.lo  = is_write & be[0];
            drive.mid = is_write & be[1];
            drive.top = is_write & be[1];
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_OE_NS   = 35,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_WP_NS   = 55,
    parameter int unsigned T_AW_NS   = 65,
    parameter int unsigned T_DW_NS   = 35,
    parameter int unsigned T_OHZ_NS  = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_byte_mode,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [1:0]        req_be,
    input  logic [15:0]       req_wdata,
    output logic              req_ack,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic [1:0]        mem_lane_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_x16,
    output logic [15:0]       dq_out,
    output logic              dq_drv_lo,
    output logic              dq_drv_mid,
    output logic              dq_drv_top,
    input  logic [15:0]       dq_in
);
    localparam int unsigned RD_CYC = umax(1, umax(umax(ns_to_cyc(T_AA_NS, CLK_NS) - 1,
                                                       ns_to_cyc(T_OE_NS, CLK_NS)),
                                                  ns_to_cyc(T_RC_NS, CLK_NS) - 1));
    localparam int unsigned WR_CYC = umax(1, umax(umax(ns_to_cyc(T_WP_NS, CLK_NS),
                                                       ns_to_cyc(T_AW_NS, CLK_NS) - 1),
                                                  umax(ns_to_cyc(T_DW_NS, CLK_NS) - 1,
                                                       ns_to_cyc(T_WC_NS, CLK_NS) - 1)));
    localparam int unsigned TURN_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int unsigned CNT_W    = $clog2(umax(umax(RD_CYC, WR_CYC), TURN_CYC) + 1);

    ctl_state_e       state;
    strobe_t          strb;
    drive_t           drv;
    logic             op_write;
    logic             op_byte;

    logic [LANES-1:0] map_lane_n;
    logic             map_any;
    drive_t           map_drive;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    asram_lane_map u_lane_map (
        .byte_mode (req_byte_mode),
        .is_write  (req_write),
        .be        (req_be),
        .lane_n    (map_lane_n),
        .any_lane  (map_any),
        .drive     (map_drive)
    );

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Timer is armed on entry to the strobe and to the turnaround.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state == ST_SETUP) begin
            tmr_load = 1'b1;
            tmr_val  = op_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end else if (state == ST_STROBE && tmr_done && !op_write) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TURN_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            strb      <= STROBE_OFF;
            drv       <= '0;
            op_write  <= 1'b0;
            op_byte   <= 1'b0;
            mem_addr  <= '0;
            mem_x16   <= 1'b1;
            dq_out    <= '0;
            req_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            req_ack <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && !req_ack) begin
                        if (!map_any) begin
                            req_ack <= 1'b1;          // nothing to access
                        end else begin
                            state       <= ST_SETUP;
                            op_write    <= req_write;
                            op_byte     <= req_byte_mode;
                            mem_addr    <= req_addr[ADDR_W:1];
                            mem_x16     <= !req_byte_mode;
                            strb.cs1_n  <= 1'b0;
                            strb.cs2    <= 1'b1;
                            strb.lane_n <= map_lane_n;
                            drv         <= map_drive;
                            if (req_byte_mode)
                                dq_out <= {req_addr[0], 7'd0, req_wdata[7:0]};
                            else
                                dq_out <= req_wdata;
                        end
                    end
                end
                ST_SETUP: begin
                    state <= ST_STROBE;
                    if (op_write) strb.we_n <= 1'b0;
                    else          strb.oe_n <= 1'b0;
                end
                ST_STROBE: begin
                    if (tmr_done) begin
                        req_ack <= 1'b1;
                        if (op_write) begin
                            strb.we_n <= 1'b1;
                            state     <= ST_HOLD;
                        end else begin
                            rsp_rdata <= op_byte ? {8'h00, dq_in[7:0]} : dq_in;
                            strb      <= STROBE_OFF;
                            drv       <= '0;
                            state     <= ST_TURN;
                        end
                    end
                end
                ST_HOLD: begin
                    strb  <= STROBE_OFF;
                    drv   <= '0;
                    state <= ST_IDLE;
                end
                ST_TURN: begin
                    if (tmr_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_cs1_n  = strb.cs1_n;
    assign mem_cs2    = strb.cs2;
    assign mem_lane_n = strb.lane_n;
    assign mem_we_n   = strb.we_n;
    assign mem_oe_n   = strb.oe_n;
    assign dq_drv_lo  = drv.lo;
    assign dq_drv_mid = drv.mid;
    assign dq_drv_top = drv.top;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned CLK_NS   = 8,
    parameter int unsigned T_OE_NS  = 35,
    parameter int unsigned T_WP_NS  = 55,
    parameter int unsigned T_OHZ_NS = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic [1:0]        mem_lane_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_x16,
    input logic [15:0]       dq_out,
    input logic              dq_drv_lo,
    input logic              dq_drv_mid,
    input logic              dq_drv_top
);
    localparam int unsigned WP_C   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned OE_C   = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int unsigned OHZ_C  = ns_to_cyc(T_OHZ_NS, CLK_NS);

    logic selected;
    logic any_drive;
    assign selected  = !mem_cs1_n && mem_cs2 && (mem_lane_n != 2'b11);
    assign any_drive = dq_drv_lo || dq_drv_mid || dq_drv_top;

    int unsigned we_lo_cnt;
    int unsigned oe_lo_cnt;
    int unsigned oe_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= 0;
            oe_lo_cnt <= 0;
            oe_hi_cnt <= OHZ_C;
        end else begin
            we_lo_cnt <= mem_we_n ? 0 : we_lo_cnt + 1;
            oe_lo_cnt <= mem_oe_n ? 0 : oe_lo_cnt + 1;
            if (!mem_oe_n)            oe_hi_cnt <= 0;
            else if (oe_hi_cnt < OHZ_C) oe_hi_cnt <= oe_hi_cnt + 1;
        end
    end

    a_r1_write_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> selected);
    a_r1_select_before_write: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(selected));
    a_r2_read_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (selected && mem_we_n));
    a_r3_no_drive_deselected: assert property (@(posedge clk) disable iff (rst)
        !selected |-> !any_drive);
    a_r4_byte_lanes: assert property (@(posedge clk) disable iff (rst)
        (!mem_x16 && selected) |-> (mem_lane_n == 2'b00 && !dq_drv_mid));
    a_r8_write_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_cnt >= WP_C));
    a_r8_write_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(dq_out)));
    a_r7_oe_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_lo_cnt >= OE_C));
    a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
        (mem_oe_n && any_drive) |-> (oe_hi_cnt >= OHZ_C));
    a_r9_no_fight: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !(dq_drv_lo || dq_drv_mid));
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .CLK_NS   (CLK_NS),
    .T_OE_NS  (T_OE_NS),
    .T_WP_NS  (T_WP_NS),
    .T_OHZ_NS (T_OHZ_NS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ack    (req_ack),
    .mem_addr   (mem_addr),
    .mem_cs1_n  (mem_cs1_n),
    .mem_cs2    (mem_cs2),
    .mem_lane_n (mem_lane_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_x16    (mem_x16),
    .dq_out     (dq_out),
    .dq_drv_lo  (dq_drv_lo),
    .dq_drv_mid (dq_drv_mid),
    .dq_drv_top (dq_drv_top)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int AW = 6;
    localparam int CLK_NS = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected intervals from the timing figures (70/70/35 read, 70/55/65/35 write, 25 turn-off)
    localparam int RD_N   = mx(1, mx(mx(cyc(70) - 1, cyc(35)), cyc(70) - 1));
    localparam int WR_N   = mx(1, mx(mx(cyc(55), cyc(65) - 1), mx(cyc(35) - 1, cyc(70) - 1)));
    localparam int TURN_N = cyc(25);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_NS/2) clk = ~clk;

    logic          req_valid = 0, req_write = 0, req_byte_mode = 0;
    logic [AW:0]   req_addr = '0;
    logic [1:0]    req_be = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_ack;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_x16;
    logic [1:0]    mem_lane_n;
    logic [15:0]   dq_out, dq_in;
    logic          dq_drv_lo, dq_drv_mid, dq_drv_top;

    asram_ctrl #(.ADDR_W(AW), .CLK_NS(CLK_NS)) u_asram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_byte_mode(req_byte_mode), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_lane_n(mem_lane_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_x16(mem_x16), .dq_out(dq_out), .dq_drv_lo(dq_drv_lo),
        .dq_drv_mid(dq_drv_mid), .dq_drv_top(dq_drv_top), .dq_in(dq_in)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- pin-level memory model ----------------
    logic [15:0] marr [1 << AW];
    logic [15:0] shadow [1 << AW];
    logic        sel;
    assign sel = !mem_cs1_n && mem_cs2 && (mem_lane_n != 2'b11);

    always_comb begin
        dq_in = 16'h5A5A;
        if (sel && !mem_oe_n && mem_we_n) begin
            if (mem_x16) begin
                if (!mem_lane_n[0]) dq_in[7:0]  = marr[mem_addr][7:0];
                if (!mem_lane_n[1]) dq_in[15:8] = marr[mem_addr][15:8];
            end else if (dq_drv_top) begin
                dq_in[7:0] = dq_out[15] ? marr[mem_addr][15:8] : marr[mem_addr][7:0];
            end else begin
                dq_in[7:0] = 8'hEE;
            end
        end
    end

    bit          w_pend = 0;
    logic [AW-1:0] w_addr;
    logic [15:0] w_data;
    logic [1:0]  w_lane_n;
    logic        w_x16, w_top, w_dlo, w_dmid;
    always @(negedge clk) begin
        if (!rst && !mem_we_n && sel) begin
            w_pend = 1; w_addr = mem_addr; w_data = dq_out; w_lane_n = mem_lane_n;
            w_x16 = mem_x16; w_top = dq_drv_top; w_dlo = dq_drv_lo; w_dmid = dq_drv_mid;
        end else if (w_pend && mem_we_n) begin
            w_pend = 0;
            if (w_x16) begin
                if (!w_lane_n[0]) marr[w_addr][7:0]  = w_dlo ? w_data[7:0] : 8'hEE;
                if (!w_lane_n[1]) marr[w_addr][15:8] = (w_dmid && w_top) ? w_data[15:8] : 8'hEE;
            end else begin
                if (!w_top)        marr[w_addr][7:0]  = 8'hEE;
                else if (w_data[15]) marr[w_addr][15:8] = w_dlo ? w_data[7:0] : 8'hEE;
                else               marr[w_addr][7:0]  = w_dlo ? w_data[7:0] : 8'hEE;
            end
        end
    end

    // ---------------- pin-timing monitor ----------------
    int  we_lo = 0, oe_lo = 0, oe_hi = 1000;
    bit  we_bad = 0, oe_bad = 0, drv_prev = 0;
    logic [AW-1:0] we_a;
    logic [15:0]   we_d;
    always @(negedge clk) begin
        if (!rst) begin
            bit drv;
            drv = dq_drv_lo || dq_drv_mid || dq_drv_top;
            if (!mem_we_n) begin
                if (we_lo == 0) begin we_a = mem_addr; we_d = dq_out; end
                else if (mem_addr != we_a || dq_out != we_d) we_bad = 1;
                if (!sel) we_bad = 1;
                we_lo++;
            end else if (we_lo > 0) begin
                chk(we_lo == WR_N, "R8 write-enable low cycles", we_lo, WR_N);
                chk(!we_bad && sel, "R1/R8 select and stability during write", {31'd0, we_bad}, 0);
                we_lo = 0; we_bad = 0;
            end
            if (!mem_oe_n) begin
                if (!mem_we_n || !sel || dq_drv_lo || dq_drv_mid) oe_bad = 1;
                oe_lo++; oe_hi = 0;
            end else begin
                if (oe_lo > 0) begin
                    chk(oe_lo == RD_N, "R7 output-enable low cycles", oe_lo, RD_N);
                    chk(!oe_bad, "R2 read strobe conditions", {31'd0, oe_bad}, 0);
                    oe_lo = 0; oe_bad = 0;
                end
                if (drv && !drv_prev) begin
                    chk(oe_hi >= TURN_N, "R9 turnaround before drive", oe_hi, TURN_N);
                    chk(sel, "R3 drive only while selected", {31'd0, sel}, 1);
                    if (!mem_x16)
                        chk(!dq_drv_mid && mem_lane_n == 2'b00, "R4 byte-mode lanes and pins",
                            {28'd0, dq_drv_mid, 1'b0, mem_lane_n}, 0);
                end
                oe_hi++;
            end
            drv_prev = drv;
        end
    end

    // ---------------- request driver ----------------
    int prev_kind = 0;   // 0 none, 1 read, 2 write, 3 empty
    int strobe_seen;

    task automatic do_op(input bit w, input bit bm, input logic [AW:0] a, input logic [1:0] be,
                         input logic [15:0] wd, input string tag);
        int lat, exp_lat, extra;
        bit p_we, p_oe, done, empty;
        logic [15:0] exp_rd, sh;
        empty = !bm && (be == 2'b00);
        extra = (prev_kind == 1) ? TURN_N : (prev_kind == 0 ? 0 : 1);
        exp_lat = empty ? 1 : (2 + (w ? WR_N : RD_N));
        exp_lat += extra;
        sh = shadow[a[AW:1]];
        if (bm) exp_rd = {8'h00, a[0] ? sh[15:8] : sh[7:0]};
        else    exp_rd = {be[1] ? sh[15:8] : 8'h5A, be[0] ? sh[7:0] : 8'h5A};
        req_valid = 1; req_write = w; req_byte_mode = bm; req_addr = a; req_be = be; req_wdata = wd;
        lat = 0; done = 0; strobe_seen = 0;
        while (!done) begin
            p_we = mem_we_n; p_oe = mem_oe_n;
            @(negedge clk);
            lat++;
            if (!mem_cs1_n) strobe_seen++;
            if (req_ack || lat > 500) done = 1;
        end
        chk(lat == exp_lat, {"R10 ack latency ", tag}, lat, exp_lat);
        if (empty) begin
            chk(strobe_seen == 0, "R6 no strobe for empty enables", strobe_seen, 0);
        end else if (w) begin
            chk(mem_we_n && !p_we, "R10 write ack after write-enable rise", {p_we, mem_we_n}, 2'b01);
        end else begin
            chk(mem_oe_n && !p_oe, "R10 read ack after output-enable rise", {p_oe, mem_oe_n}, 2'b01);
            chk(rsp_rdata == exp_rd, {bm ? "R4 byte read " : "R2/R5 word read ", tag}, rsp_rdata, exp_rd);
        end
        req_valid = 0;
        if (w && !empty) begin
            if (bm) begin
                if (a[0]) shadow[a[AW:1]][15:8] = wd[7:0];
                else      shadow[a[AW:1]][7:0]  = wd[7:0];
            end else begin
                if (be[0]) shadow[a[AW:1]][7:0]  = wd[7:0];
                if (be[1]) shadow[a[AW:1]][15:8] = wd[15:8];
            end
        end
        prev_kind = empty ? 3 : (w ? 2 : 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < (1 << AW); i++) begin
            marr[i] = 16'(i * 16'h0101);
            shadow[i] = 16'(i * 16'h0101);
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R3: reset state
        chk(mem_cs1_n && !mem_cs2 && mem_lane_n == 2'b11 && mem_we_n && mem_oe_n,
            "R3 strobes idle after reset", {27'd0, mem_cs1_n, mem_cs2, mem_lane_n, mem_we_n}, 5'b10111);
        chk(!(dq_drv_lo || dq_drv_mid || dq_drv_top) && mem_x16 && !req_ack,
            "R3 no drive, word width after reset", {29'd0, dq_drv_lo, dq_drv_mid, dq_drv_top}, 0);

        do_op(1, 0, {6'd5, 1'b0}, 2'b00, 16'hFFFF, "R6 empty write");
        do_op(1, 0, {6'd5, 1'b0}, 2'b11, 16'h1234, "R1 full word write");
        do_op(0, 0, {6'd5, 1'b0}, 2'b11, 16'h0000, "R2 full word read");
        do_op(1, 1, {6'd5, 1'b1}, 2'b00, 16'h77AB, "R4 byte write upper");
        do_op(0, 0, {6'd5, 1'b0}, 2'b11, 16'h0000, "R4 word read after byte write");
        do_op(0, 1, {6'd5, 1'b0}, 2'b00, 16'h0000, "R4 byte read lower");
        do_op(1, 0, {6'd5, 1'b0}, 2'b10, 16'hCD99, "R5 upper-lane write");
        do_op(0, 0, {6'd5, 1'b0}, 2'b01, 16'h0000, "R5 lower-lane read");
        do_op(0, 0, {6'd5, 1'b0}, 2'b11, 16'h0000, "R5 read after lane write");
        do_op(0, 0, {6'd9, 1'b0}, 2'b00, 16'h0000, "R6 empty read");

        for (int k = 0; k < 300; k++) begin
            bit w, bm;
            logic [AW:0] a;
            logic [1:0] be;
            w  = 1'($urandom);
            bm = ($urandom % 3) == 0;
            a  = (AW+1)'($urandom);
            be = 2'($urandom);
            do_op(w, bm, a, be, 16'($urandom), "random");
        end
        for (int i = 0; i < (1 << AW); i++)
            do_op(0, 0, {6'(i), 1'b0}, 2'b11, 16'h0000, "R2 final sweep");
        finish_run();
    end
endmodule